// File: doc/BRIEF.md
# Two-Trigger Delayed One-Shot Pulse Timer

This block produces one output pulse per pair of triggers. A start event, either a selected edge on the start pin or a single-cycle software strobe, arms a down-counter. That counter loads a programmable delay and counts count-clock enables. When it runs out, the output goes active and a delay interrupt pulses. A selected edge on the end pin then drops the output again. In the same cycle, the number of count ticks the pulse lasted is latched into a capture register with an overflow flag, and a capture interrupt pulses.

The block runs on a single operation clock. A count-clock enable marks the ticks that advance the counters. Both trigger pins are asynchronous, so each passes through its own synchronizer and edge detector. The pulse width in count-clock periods is (overflow × 65536) + captured value + 1. This figure is exact only when the counter wrapped at most once while the pulse was active.

Top module: `dual_trig_oneshot`

## Requirements
- R1: Each trigger pin is synchronized through two flops and edge-detected. Its select input chooses the edge: 0 means rising, 1 means falling. A transition in the other direction is not a trigger. A pin change made before clock edge k is acted on at edge k+2.
- R2: An accepted start loads `delay_val` on the next enabled edge. The output then becomes active D+2 enabled edges after the edge that accepted the start, where D is the delay value. With `cnt_en` held high, a strobe seen at edge E gives an active output after edge E+D+2, and a start-pin change before edge k gives an active output after edge k+D+4.
- R3: At expiry, `delay_irq` is high for exactly one cycle and `pulse_out` goes high in the same cycle. The delay counter then stays idle, with no further `delay_irq`, until a new start.
- R4: A start that arrives while the delay countdown is still running is ignored and does not restart the countdown.
- R5: While `pulse_out` is high, an end edge has the following effect at the acceptance edge: it copies the width counter to `cap_val`, clears the counter, drives `pulse_out` low and pulses `cap_irq` for one cycle. `cap_val` equals the number of enabled edges strictly between the rising and falling edges of `pulse_out`, modulo 65536.
- R6: At each capture, `cap_ovf` is set when the width counter wrapped from FFFFH to 0000H during the active period, and is cleared otherwise.
- R7: An end edge while `pulse_out` is low has no effect: `cap_irq` stays low and `cap_val` is unchanged.
- R8: Both counters advance only on clock edges where `cnt_en` is high. Trigger detection does not depend on `cnt_en`.
- R9: While reset is active, and straight after it is released, `pulse_out`, `delay_irq`, `cap_irq`, `cap_val` and `cap_ovf` are all zero.
- R10: After a capture, the start/expire/end sequence repeats for any number of trigger pairs with any delay values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operation clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count-clock enable, one cycle per count tick |
| start_pin | input | 1 | Asynchronous start trigger pin |
| end_pin | input | 1 | Asynchronous end trigger pin |
| sw_start | input | 1 | Software start strobe, one cycle |
| start_fall_sel | input | 1 | Start edge select: 0 rising, 1 falling |
| end_fall_sel | input | 1 | End edge select: 0 rising, 1 falling |
| delay_val | input | 16 | Programmed delay value D |
| pulse_out | output | 1 | One-shot pulse output, active high |
| delay_irq | output | 1 | One-cycle pulse when the delay expires |
| cap_irq | output | 1 | One-cycle pulse when the width is captured |
| cap_val | output | 16 | Captured width counter value |
| cap_ovf | output | 1 | Width counter wrapped during the captured pulse |

## Verification
The assertions assume the following about the inputs:
- The select inputs do not change in the cycle an edge is being detected.
- `sw_start` is a single-cycle strobe.
- Each pin level is held for at least two operation clocks, so every edge passes through the synchronizer as a clean step.

The stimulus drives every input just after a clock edge, holds each pin level for three or more cycles, and changes edge selects only while the matching pin is idle. It also drops the start pin only after the output has gone active, so that a falling edge never lands on a busy countdown without intent.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    localparam int unsigned OS_W = 16;

    typedef logic [OS_W-1:0] os_cnt_t;

    typedef struct packed {
        logic    busy;
        logic    loaded;
        logic    irq;
        os_cnt_t cnt;
    } dly_state_t;

    typedef struct packed {
        os_cnt_t cnt;
        logic    wrap_seen;
        os_cnt_t cap;
        logic    ovf;
        logic    irq;
    } wid_state_t;

    typedef struct packed {
        logic pulse;
    } top_state_t;

endpackage

// File: rtl/trig_edge_det.sv
module trig_edge_det #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_o
);
    localparam int unsigned SH_W = STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;
    logic            cur, prev;

    always_comb begin
        sh_d   = {sh_q[SH_W-2:0], pin};
        cur    = sh_q[STAGES-1];
        prev   = sh_q[STAGES];
        edge_o = fall_sel ? (prev & ~cur) : (cur & ~prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // R1: a detected edge cannot repeat on the next cycle
    p_edge_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o && $stable(fall_sel) |=> !edge_o);

endmodule

// File: rtl/oneshot_delay_ctr.sv
module oneshot_delay_ctr
    import oneshot_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cnt_en,
    input  logic    start,
    input  os_cnt_t delay_val,
    output logic    expire,
    output logic    irq
);
    dly_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        expire   = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy   = 1'b1;
                st_d.loaded = 1'b0;
            end
        end else if (cnt_en) begin
            if (!st_q.loaded) begin
                st_d.cnt    = delay_val;
                st_d.loaded = 1'b1;
            end else if (st_q.cnt == '0) begin
                expire      = 1'b1;
                st_d.busy   = 1'b0;
                st_d.loaded = 1'b0;
                st_d.irq    = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.irq;

    // R3: expiry interrupt lasts one cycle
    p_irq_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |=> !st_q.irq);

    // R2: the first enabled tick after a start loads the programmed delay
    p_load_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy && !st_q.loaded && cnt_en |=> st_q.cnt == $past(delay_val));

    // R4: a running countdown stays running until it expires
    p_no_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy && !expire |=> st_q.busy);

    // R8: no count movement without an enable
    p_hold_no_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy && st_q.loaded && !cnt_en |=> $stable(st_q.cnt));

endmodule

// File: rtl/oneshot_width_cap.sv
module oneshot_width_cap
    import oneshot_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cnt_en,
    input  logic    arm,
    input  logic    active,
    input  logic    end_trig,
    output logic    fire,
    output os_cnt_t cap_val,
    output logic    cap_ovf,
    output logic    cap_irq
);
    wid_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        fire     = active & end_trig;
        if (fire) begin
            st_d.cap       = st_q.cnt;
            st_d.ovf       = st_q.wrap_seen;
            st_d.irq       = 1'b1;
            st_d.cnt       = '0;
            st_d.wrap_seen = 1'b0;
        end else if (active && cnt_en) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == '1) st_d.wrap_seen = 1'b1;
        end
        if (arm) begin
            st_d.cnt       = '0;
            st_d.wrap_seen = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_val = st_q.cap;
    assign cap_ovf = st_q.ovf;
    assign cap_irq = st_q.irq;

    // R5: counter restarts from zero after a capture
    p_clear_after_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> st_q.cnt == '0);

    // R6: a wrap inside the active period is remembered
    p_wrap_noted_r6: assert property (@(posedge clk) disable iff (!rst_n)
        active && cnt_en && st_q.cnt == '1 && !end_trig && !arm |=> st_q.wrap_seen);

    // R7: captured value untouched while the output is inactive
    p_idle_keeps_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> $stable(st_q.cap));

endmodule

// File: rtl/dual_trig_oneshot.sv
module dual_trig_oneshot
    import oneshot_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cnt_en,
    input  logic            start_pin,
    input  logic            end_pin,
    input  logic            sw_start,
    input  logic            start_fall_sel,
    input  logic            end_fall_sel,
    input  logic [OS_W-1:0] delay_val,
    output logic            pulse_out,
    output logic            delay_irq,
    output logic            cap_irq,
    output logic [OS_W-1:0] cap_val,
    output logic            cap_ovf
);
    top_state_t st_d, st_q;
    logic       start_edge, end_edge, start_any;
    logic       expire, fire;

    trig_edge_det #(.STAGES(SYNC_STAGES)) u_start_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (start_pin),
        .fall_sel (start_fall_sel),
        .edge_o   (start_edge)
    );

    trig_edge_det #(.STAGES(SYNC_STAGES)) u_end_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (end_pin),
        .fall_sel (end_fall_sel),
        .edge_o   (end_edge)
    );

    assign start_any = start_edge | sw_start;

    oneshot_delay_ctr u_delay (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en    (cnt_en),
        .start     (start_any),
        .delay_val (delay_val),
        .expire    (expire),
        .irq       (delay_irq)
    );

    oneshot_width_cap u_width (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_en   (cnt_en),
        .arm      (expire),
        .active   (st_q.pulse),
        .end_trig (end_edge),
        .fire     (fire),
        .cap_val  (cap_val),
        .cap_ovf  (cap_ovf),
        .cap_irq  (cap_irq)
    );

    always_comb begin
        st_d = st_q;
        if (expire)    st_d.pulse = 1'b1;
        else if (fire) st_d.pulse = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_out = st_q.pulse;

    // R3: output is active whenever the delay interrupt pulses
    p_active_on_expiry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        delay_irq |-> pulse_out);

    // R5: output is inactive when a capture is reported
    p_inactive_on_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_irq && !delay_irq |-> !pulse_out);

endmodule

// File: tb/test_dual_trig_oneshot.sv
`timescale 1ns/1ps
module test_dual_trig_oneshot;

    typedef struct packed {
        logic [15:0] dly;
        logic [15:0] hold;
        logic        sw;
    } vec_t;

    // delay, cycles held active before the end edge, start by strobe
    localparam vec_t VECS [0:7] = '{
        '{16'd0,   16'd1,   1'b1},
        '{16'd0,   16'd1,   1'b0},
        '{16'd1,   16'd2,   1'b0},
        '{16'd2,   16'd5,   1'b1},
        '{16'd7,   16'd3,   1'b0},
        '{16'd30,  16'd40,  1'b1},
        '{16'd100, 16'd9,   1'b0},
        '{16'd15,  16'd200, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n, cnt_en, start_pin, end_pin, sw_start;
    logic        start_fall_sel, end_fall_sel;
    logic [15:0] delay_val;
    logic        pulse_out, delay_irq, cap_irq, cap_ovf;
    logic [15:0] cap_val;

    int n_chk = 0;
    int n_bad = 0;
    int last_cap = 0;

    always #2 clk = ~clk;

    dual_trig_oneshot i_dual_trig_oneshot (
        .clk            (clk),
        .rst_n          (rst_n),
        .cnt_en         (cnt_en),
        .start_pin      (start_pin),
        .end_pin        (end_pin),
        .sw_start       (sw_start),
        .start_fall_sel (start_fall_sel),
        .end_fall_sel   (end_fall_sel),
        .delay_val      (delay_val),
        .pulse_out      (pulse_out),
        .delay_irq      (delay_irq),
        .cap_irq        (cap_irq),
        .cap_val        (cap_val),
        .cap_ovf        (cap_ovf)
    );

    task automatic check_eq(input string req, input string what,
                            input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_rise(input int exp_e, input string req);
        int e = 0;
        while (!pulse_out && e < exp_e + 4) begin
            tick();
            e++;
        end
        check_eq(req, "edges to active output", e, exp_e);
        check_eq("R3", "delay_irq at expiry", delay_irq, 1);
    endtask

    task automatic finish_pulse(input int hold, input string req);
        int  e = 0;
        bit  stray = 0;
        int  exp_cap = (hold + 2) % 65536;
        int  exp_ovf = ((hold + 2) > 65535) ? 1 : 0;
        tick();
        check_eq("R3", "delay_irq one cycle", delay_irq, 0);
        repeat (hold - 1) begin
            tick();
            if (delay_irq || !pulse_out) stray = 1;
        end
        check_eq("R3", "idle after expiry", stray, 0);
        end_pin = 1'b1;
        while (pulse_out && e < 8) begin
            tick();
            e++;
        end
        check_eq("R5", "edges to capture", e, 3);
        check_eq("R5", "cap_irq at capture", cap_irq, 1);
        check_eq(req, "captured width", cap_val, exp_cap);
        check_eq("R6", "overflow flag", cap_ovf, exp_ovf);
        last_cap = exp_cap;
        tick();
        check_eq("R5", "cap_irq one cycle", cap_irq, 0);
        end_pin = 1'b0;
        repeat (3) tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cnt_en = 1'b0; start_pin = 1'b0; end_pin = 1'b0;
        sw_start = 1'b0; start_fall_sel = 1'b0; end_fall_sel = 1'b0;
        delay_val = '0;
        repeat (3) tick();
        // R9: reset state
        check_eq("R9", "pulse_out in reset", pulse_out, 0);
        check_eq("R9", "cap_val in reset", cap_val, 0);
        rst_n = 1'b1;
        cnt_en = 1'b1;
        tick();
        check_eq("R9", "outputs after release",
                 {pulse_out, delay_irq, cap_irq, cap_ovf, cap_val}, 0);

        // R10, R2: table of trigger pairs, repeated back to back
        for (int i = 0; i < 8; i++) begin
            delay_val = VECS[i].dly;
            if (VECS[i].sw) begin
                sw_start = 1'b1;
                tick();
                sw_start = 1'b0;
                wait_rise(int'(VECS[i].dly) + 2, "R2");
            end else begin
                start_pin = 1'b1;
                wait_rise(int'(VECS[i].dly) + 5, "R2");
                start_pin = 1'b0;
            end
            finish_pulse(int'(VECS[i].hold), "R10");
        end

        // R4: second strobe during the countdown is ignored
        delay_val = 16'd20;
        sw_start = 1'b1; tick(); sw_start = 1'b0;
        repeat (5) tick();
        sw_start = 1'b1; tick(); sw_start = 1'b0;
        wait_rise(16, "R4");
        finish_pulse(2, "R4");

        // R7: end edge while inactive
        begin
            bit seen = 0;
            end_pin = 1'b1;
            repeat (6) begin
                tick();
                if (cap_irq) seen = 1;
            end
            check_eq("R7", "cap_irq while inactive", seen, 0);
            check_eq("R7", "cap_val unchanged", cap_val, last_cap);
            end_pin = 1'b0;
            repeat (3) tick();
        end

        // R1: falling-edge select on start; a rising edge is not a trigger
        delay_val = 16'd3;
        start_fall_sel = 1'b1;
        tick();
        begin
            bit early = 0;
            start_pin = 1'b1;
            repeat (20) begin
                tick();
                if (pulse_out) early = 1;
            end
            check_eq("R1", "rising edge under falling select", early, 0);
        end
        start_pin = 1'b0;
        wait_rise(8, "R1");
        finish_pulse(4, "R1");
        start_fall_sel = 1'b0;
        tick();

        // R1: falling-edge select on end
        end_fall_sel = 1'b1;
        end_pin = 1'b1;
        repeat (4) tick();
        delay_val = 16'd2;
        sw_start = 1'b1; tick(); sw_start = 1'b0;
        wait_rise(4, "R1");
        tick();
        end_pin = 1'b0;
        begin
            int e = 0;
            while (pulse_out && e < 8) begin
                tick();
                e++;
            end
            check_eq("R1", "falling end edge captures", e, 3);
            check_eq("R1", "captured width on falling end", cap_val, 3);
        end
        end_fall_sel = 1'b0;
        repeat (3) tick();

        // R8: count enable on every other edge
        delay_val = 16'd4;
        cnt_en = 1'b0;
        sw_start = 1'b1; tick(); sw_start = 1'b0;
        begin
            int en_n = 0;
            int edges = 0;
            int steps = 0;
            while (!pulse_out && edges < 100) begin
                cnt_en = ~cnt_en;
                tick();
                edges++;
                if (cnt_en) en_n++;
            end
            check_eq("R8", "enabled ticks to expiry", en_n, 6);
            check_eq("R8", "raw edges to expiry", edges, 11);
            while (pulse_out && steps < 100) begin
                cnt_en = ~cnt_en;
                if (steps == 6) end_pin = 1'b1;
                tick();
                steps++;
            end
            check_eq("R8", "edges to gated capture", steps, 9);
            check_eq("R8", "gated width", cap_val, 4);
        end
        cnt_en = 1'b1;
        end_pin = 1'b0;
        repeat (3) tick();

        // R6: one wrap of the width counter, then a clean pulse
        delay_val = 16'd0;
        sw_start = 1'b1; tick(); sw_start = 1'b0;
        wait_rise(2, "R6");
        finish_pulse(65539, "R6");
        sw_start = 1'b1; tick(); sw_start = 1'b0;
        wait_rise(2, "R6");
        finish_pulse(3, "R6");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule